// File: doc/BRIEF.md
# Pixel Word Clock-Crossing FIFO

This block moves pixel words, each carrying a start-of-frame mark and an end-of-line mark, from a video pixel clock domain into a stream clock domain. Writes are made on the pixel clock, and the writer stops offering words while the full flag is high. Reads are made on the stream clock, and the reader asks for a word with a one-cycle strobe. Each read is answered one cycle later with a valid flag, or with an error flag if the FIFO held nothing at the moment of the strobe.

Both pointers are plain binary counters. Gray coding is not used. Each pointer reaches the other domain through a toggle handshake. The sending side copies its live pointer into a holding register and flips a request bit. The receiving side synchronizes that bit, sees that it differs from its own acknowledge bit, takes the held value, and flips the acknowledge bit to match. When the acknowledge bit arrives back, the sender is free to take a fresh sample. The pointer seen on the far side therefore lags the live one, so the full and empty flags are conservative.

Depth is a power of two from 32 to 8192 entries, and the pixel width is a parameter. Each domain has its own active-high synchronous reset.

Top module: `pix_cdc_fifo`

## Requirements
- R1: After reset, rd_empty is 1, wr_full is 0, and rd_valid and rd_error are both 0.
- R2: Words leave in the order they were accepted. rd_data equals the accepted wr_data, and rd_sof and rd_eol equal the wr_sof and wr_eol given with that word.
- R3: With no reads made and the read pointer copy settled, exactly DEPTH writes are accepted and then wr_full is 1. Further write strobes while wr_full is 1 are ignored and never overwrite stored words.
- R4: A read strobe seen while rd_empty is 1 gives rd_error = 1 on the next rd_clk cycle. rd_data, rd_sof and rd_eol keep their previous values, and the read pointer does not advance, so the next stored word is still delivered.
- R5: A read strobe seen while rd_empty is 0 gives rd_valid = 1 on the next rd_clk cycle. rd_valid and rd_error are never both 1, and both are 0 in a cycle that follows no strobe.
- R6: Once writes stop, every stored word can be read out and rd_empty returns to 1. Once reads drain a full FIFO, wr_full returns to 0 within a bounded number of cycles.
- R7: The pointer copy received in either domain is never more than DEPTH entries away from the live pointer it is compared with.
- R8: R2 holds both when the stream clock is faster than the pixel clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Pixel clock (write domain) |
| wr_rst | input | 1 | Active-high synchronous reset, write domain |
| wr_en | input | 1 | Write strobe; accepted when wr_full is 0 |
| wr_data | input | DATA_W | Pixel word to store |
| wr_sof | input | 1 | Start-of-frame mark for this word |
| wr_eol | input | 1 | End-of-line mark for this word |
| wr_full | output | 1 | No free entry, as seen from the write domain |
| rd_clk | input | 1 | Stream clock (read domain) |
| rd_rst | input | 1 | Active-high synchronous reset, read domain |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Pixel word from the last good read |
| rd_sof | output | 1 | Start-of-frame mark of that word |
| rd_eol | output | 1 | End-of-line mark of that word |
| rd_valid | output | 1 | The previous-cycle strobe returned a word |
| rd_error | output | 1 | The previous-cycle strobe found the FIFO empty |
| rd_empty | output | 1 | No word visible, as seen from the read domain |

## Verification
The bench looks for overflow by writing DEPTH plus six words with no reads. A design whose write inhibit is wrong would accept too many words, and the drain that follows would then return an overwritten word or one word too many. It looks for underflow by reading continuously until the FIFO runs dry. A design that advanced the read pointer on an empty read would skip a word later or return stale data, and one that loaded the output register anyway would change rd_data while flagging an error. The stream clock is run both faster and slower than the pixel clock with irregular gaps. A broken handshake would lose or repeat pointer updates, and the bench would see this as reordered words or as flags that never recover.

// File: rtl/pixq_pkg.sv
package pixq_pkg;

    localparam int MIN_DEPTH = 32;
    localparam int MAX_DEPTH = 8192;

    typedef struct packed {
        logic sof;
        logic eol;
    } pix_tag_t;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_WORD  = 2'd1,
        RES_FAULT = 2'd2
    } rd_res_e;

    function automatic bit depth_legal(input int d);
        return (d >= MIN_DEPTH) && (d <= MAX_DEPTH) && ((d & (d - 1)) == 0);
    endfunction

endpackage

// File: rtl/pixq_sync2.sv
module pixq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/pixq_xfer_src.sv
module pixq_xfer_src #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] live_ptr,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic [PW-1:0] held_ptr
);
    logic          ack_s;
    logic          req_q;
    logic [PW-1:0] hold_q;
    logic          launch;

    pixq_sync2 #(.W(1)) i_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    // Acknowledge state (req equals returned ack): free to take a new sample
    assign launch = (req_q == ack_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (launch) begin
            hold_q <= live_ptr;
            req_q  <= ~req_q;
        end
    end

    assign req_tgl  = req_q;
    assign held_ptr = hold_q;
endmodule

// File: rtl/pixq_xfer_dst.sv
module pixq_xfer_dst #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_tgl,
    input  logic [PW-1:0] held_ptr,
    output logic          ack_tgl,
    output logic [PW-1:0] ptr_copy
);
    logic          req_s;
    logic          ack_q;
    logic [PW-1:0] copy_q;

    pixq_sync2 #(.W(1)) i_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    // Request state (synced req differs from ack): held value is stable
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            copy_q <= '0;
        end else if (req_s != ack_q) begin
            copy_q <= held_ptr;
            ack_q  <= req_s;
        end
    end

    assign ack_tgl  = ack_q;
    assign ptr_copy = copy_q;
endmodule

// File: rtl/pixq_store.sv
module pixq_store #(
    parameter int AW = 5,
    parameter int W  = 26
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [W-1:0] mem [ENTRIES];
    logic [W-1:0] out_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Output register only loads on a real read; an empty read leaves it alone
    always_ff @(posedge rclk) begin
        if (rrst) begin
            out_q <= '0;
        end else if (re) begin
            out_q <= mem[raddr];
        end
    end

    assign rdata = out_q;
endmodule

// File: rtl/pix_cdc_fifo.sv
module pix_cdc_fifo
    import pixq_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 32
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sof,
    input  logic              wr_eol,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sof,
    output logic              rd_eol,
    output logic              rd_valid,
    output logic              rd_error,
    output logic              rd_empty
);
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = AW + 1;
    localparam int WORD_W = DATA_W + $bits(pix_tag_t);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        pix_tag_t          tag;
        logic [DATA_W-1:0] pix;
    } word_t;

    if (!depth_legal(DEPTH)) begin : g_bad_depth
        $error("pix_cdc_fifo: DEPTH must be a power of two from 32 to 8192");
    end

    // ---------------- write domain ----------------
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] rd_ptr_w;
    logic [PW-1:0] wr_fill;
    logic          wr_accept;
    word_t         wr_word;

    assign wr_fill   = wr_ptr_q - rd_ptr_w;
    assign wr_full   = (wr_fill == DEPTH_P);
    assign wr_accept = wr_en && !wr_full;

    always_comb begin
        wr_word.tag.sof = wr_sof;
        wr_word.tag.eol = wr_eol;
        wr_word.pix     = wr_data;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_ptr_q <= '0;
        end else if (wr_accept) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
        end
    end

    // ---------------- read domain ----------------
    logic [PW-1:0] rd_ptr_q;
    logic [PW-1:0] wr_ptr_r;
    logic          rd_take;
    rd_res_e       res_q;
    word_t         word_q;

    assign rd_empty = (wr_ptr_r == rd_ptr_q);
    assign rd_take  = rd_en && !rd_empty;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_ptr_q <= '0;
            res_q    <= RES_IDLE;
        end else begin
            if (rd_take) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            if (!rd_en) begin
                res_q <= RES_IDLE;
            end else if (rd_empty) begin
                res_q <= RES_FAULT;
            end else begin
                res_q <= RES_WORD;
            end
        end
    end

    assign rd_valid = (res_q == RES_WORD);
    assign rd_error = (res_q == RES_FAULT);
    assign rd_data  = word_q.pix;
    assign rd_sof   = word_q.tag.sof;
    assign rd_eol   = word_q.tag.eol;

    // ---------------- storage ----------------
    pixq_store #(.AW(AW), .W(WORD_W)) i_store (
        .wclk  (wr_clk),
        .we    (wr_accept),
        .waddr (wr_ptr_q[AW-1:0]),
        .wdata (wr_word),
        .rclk  (rd_clk),
        .rrst  (rd_rst),
        .re    (rd_take),
        .raddr (rd_ptr_q[AW-1:0]),
        .rdata (word_q)
    );

    // ---------------- pointer crossings ----------------
    logic          w2r_req;
    logic          w2r_ack;
    logic [PW-1:0] w2r_held;
    logic          r2w_req;
    logic          r2w_ack;
    logic [PW-1:0] r2w_held;

    pixq_xfer_src #(.PW(PW)) i_wptr_src (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .live_ptr (wr_ptr_q),
        .ack_tgl  (w2r_ack),
        .req_tgl  (w2r_req),
        .held_ptr (w2r_held)
    );

    pixq_xfer_dst #(.PW(PW)) i_wptr_dst (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .req_tgl  (w2r_req),
        .held_ptr (w2r_held),
        .ack_tgl  (w2r_ack),
        .ptr_copy (wr_ptr_r)
    );

    pixq_xfer_src #(.PW(PW)) i_rptr_src (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .live_ptr (rd_ptr_q),
        .ack_tgl  (r2w_ack),
        .req_tgl  (r2w_req),
        .held_ptr (r2w_held)
    );

    pixq_xfer_dst #(.PW(PW)) i_rptr_dst (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .req_tgl  (r2w_req),
        .held_ptr (r2w_held),
        .ack_tgl  (r2w_ack),
        .ptr_copy (rd_ptr_w)
    );
endmodule

// File: rtl/pix_cdc_fifo_chk.sv
module pix_cdc_fifo_chk #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 32,
    parameter int PW     = $clog2(DEPTH) + 1
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_full,
    input logic [PW-1:0]     wr_ptr,
    input logic [PW-1:0]     rd_ptr_w,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [PW-1:0]     rd_ptr,
    input logic [PW-1:0]     wr_ptr_r,
    input logic              rd_valid,
    input logic              rd_error,
    input logic [DATA_W+1:0] rd_word
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        PW'(wr_ptr - rd_ptr_w) <= DEPTH_P);                                    // R3

    AST_FULL_FREEZES_WPTR: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_full |=> (wr_ptr == $past(wr_ptr)));                                 // R3

    AST_EMPTY_FREEZES_RPTR: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_empty |=> (rd_ptr == $past(rd_ptr)));                                // R4

    AST_ERROR_KEEPS_WORD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_error |-> $stable(rd_word));                                         // R4

    AST_READ_ANSWERED: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_empty) |=> rd_valid);                                     // R5

    AST_VALID_ERROR_EXCL: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_valid && rd_error));                                               // R5

    AST_WCOPY_IN_RANGE: assert property (@(posedge rd_clk) disable iff (rd_rst)
        PW'(wr_ptr_r - rd_ptr) <= DEPTH_P);                                     // R7
endmodule

bind pix_cdc_fifo pix_cdc_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_full  (wr_full),
    .wr_ptr   (wr_ptr_q),
    .rd_ptr_w (rd_ptr_w),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .rd_empty (rd_empty),
    .rd_ptr   (rd_ptr_q),
    .wr_ptr_r (wr_ptr_r),
    .rd_valid (rd_valid),
    .rd_error (rd_error),
    .rd_word  (word_q)
);

// File: tb/test_pix_cdc_fifo.sv
`timescale 1ns/1ps
module test_pix_cdc_fifo;
    localparam int DATA_W = 24;
    localparam int DEPTH  = 32;

    logic              wr_clk = 1'b0;
    logic              wr_rst = 1'b1;
    logic              wr_en  = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_sof = 1'b0;
    logic              wr_eol = 1'b0;
    logic              wr_full;
    logic              rd_clk = 1'b0;
    logic              rd_rst = 1'b1;
    logic              rd_en  = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_sof;
    logic              rd_eol;
    logic              rd_valid;
    logic              rd_error;
    logic              rd_empty;

    pix_cdc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_pix_cdc_fifo (.*);

    realtime rd_half = 2.0;
    always #2.0 wr_clk = ~wr_clk;
    always begin
        #(rd_half) rd_clk = ~rd_clk;
    end

    int n_checks = 0;
    int n_fail   = 0;
    string phase_req = "R2";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W+1:0] make_word(input int seq);
        logic [DATA_W-1:0] d;
        d = DATA_W'(seq * 32'h0001_01F3 + 32'h5A);
        return {(seq % 16) == 0, (seq % 8) == 7, d};
    endfunction

    // ---------------- write driver ----------------
    logic [DATA_W+1:0] exp_q[$];
    int  wr_budget   = 0;
    bit  wr_gappy    = 1'b0;
    int  wr_seq      = 0;
    int  wr_accepted = 0;
    logic [15:0] wlfsr = 16'hACE1;

    always @(negedge wr_clk) begin
        logic [DATA_W+1:0] w;
        wlfsr = {wlfsr[14:0], wlfsr[15] ^ wlfsr[13] ^ wlfsr[12] ^ wlfsr[10]};
        if (wr_rst || wr_budget == 0 || (wr_gappy && wlfsr[0])) begin
            wr_en = 1'b0;
        end else begin
            w = make_word(wr_seq);
            {wr_sof, wr_eol, wr_data} = w;
            wr_en = 1'b1;
            if (!wr_full) begin
                exp_q.push_back(w);
                wr_seq++;
                wr_accepted++;
            end
            wr_budget--;
        end
    end

    // ---------------- read driver + monitor ----------------
    typedef enum int {P_NONE, P_WORD, P_ERR} pend_e;
    pend_e pend = P_NONE;
    int rd_mode = 0;            // 0 off, 1 every cycle, 2 irregular
    int n_err_seen = 0;
    logic [DATA_W+1:0] last_out = '0;
    logic [15:0] rlfsr = 16'h1D2B;

    always @(negedge rd_clk) begin
        logic [DATA_W+1:0] got;
        logic [DATA_W+1:0] e;
        got = {rd_sof, rd_eol, rd_data};
        if (rd_rst) begin
            rd_en = 1'b0;
            pend  = P_NONE;
        end else begin
            case (pend)
                P_WORD: begin
                    chk(rd_valid && !rd_error, "R5", "answer to a good read", {rd_valid, rd_error}, 2'b10);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, phase_req, "word with nothing expected", got, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(got == e, phase_req, "word/tags out of order", got, e);
                    end
                    last_out = got;
                end
                P_ERR: begin
                    n_err_seen++;
                    chk(rd_error && !rd_valid, "R4", "answer to an empty read", {rd_valid, rd_error}, 2'b01);
                    chk(got == last_out, "R4", "output word moved on empty read", got, last_out);
                end
                default: begin
                    chk(!rd_valid && !rd_error, "R5", "flags with no strobe", {rd_valid, rd_error}, 2'b00);
                end
            endcase
            rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
            rd_en = (rd_mode == 1) || (rd_mode == 2 && rlfsr[0]);
            pend  = !rd_en ? P_NONE : (rd_empty ? P_ERR : P_WORD);
        end
    end

    task automatic wait_wr_done();
        int guard = 0;
        while (wr_budget != 0 && guard < 40000) begin
            @(posedge wr_clk);
            guard++;
        end
    endtask

    task automatic wait_drain(input string req);
        int guard = 0;
        while ((exp_q.size() != 0 || pend == P_WORD) && guard < 40000) begin
            @(posedge wr_clk);
            guard++;
        end
        repeat (40) @(posedge wr_clk);
        @(negedge rd_clk);
        chk(exp_q.size() == 0, req, "words left after drain", exp_q.size(), 0);
        chk(rd_empty == 1'b1, req, "rd_empty after drain", rd_empty, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge wr_clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (6) @(posedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        @(negedge wr_clk);
        @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R1", "rd_empty after reset", rd_empty, 1);
        chk(wr_full == 1'b0, "R1", "wr_full after reset", wr_full, 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        chk(rd_error == 1'b0, "R1", "rd_error after reset", rd_error, 0);

        // Stream clock faster than pixel clock, continuous reads (R8, R2, R4)
        phase_req = "R8";
        rd_half = 1.5;
        rd_mode = 1;
        wr_gappy = 1'b0;
        wr_budget = 200;
        wait_wr_done();
        wait_drain("R6");

        // Stream clock slower than pixel clock, irregular traffic (R8, R7)
        rd_half = 3.5;
        rd_mode = 2;
        wr_gappy = 1'b1;
        wr_budget = 300;
        wait_wr_done();
        rd_mode = 1;
        wait_drain("R6");

        // Fill with no reads: exactly DEPTH words fit (R3)
        phase_req = "R3";
        rd_half = 2.3;
        rd_mode = 0;
        repeat (40) @(posedge wr_clk);
        wr_accepted = 0;
        wr_gappy = 1'b0;
        wr_budget = DEPTH + 6;
        wait_wr_done();
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk);
        chk(wr_accepted == DEPTH, "R3", "accepted writes when filling", wr_accepted, DEPTH);
        chk(wr_full == 1'b1, "R3", "wr_full after DEPTH writes", wr_full, 1);
        @(negedge rd_clk);
        chk(rd_empty == 1'b0, "R6", "rd_empty while holding words", rd_empty, 0);
        rd_mode = 1;
        wait_drain("R3");
        repeat (40) @(posedge wr_clk);
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R6", "wr_full after drain", wr_full, 0);

        // Empty reads are followed by a correct word (R4)
        phase_req = "R4";
        repeat (10) @(posedge rd_clk);
        wr_budget = 3;
        wait_wr_done();
        wait_drain("R4");
        rd_mode = 0;
        chk(n_err_seen > 0, "R4", "empty reads were exercised", n_err_seen, 1);

        repeat (10) @(posedge wr_clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule